// File: doc/BRIEF.md
# I2C Bus Condition Monitor with Lockup Recovery

The monitor watches the two wires of an I2C bus from the system clock domain. Both lines pass through a synchronizer and a three-sample majority filter. The filtered pair is then compared against its previous value to find bus conditions:

- a START, where the data line falls while the clock line is high;
- a repeated START, which is a START seen while the bus is already busy;
- a STOP, where the data line rises while the clock line is high.

From these conditions the monitor keeps a bus-busy status. It also counts clock-line falling edges since the last START. A STOP that arrives before any clock pulse is a non-compliant empty message. The monitor flags it and returns the bus to free, so the busy status cannot stay stuck.

A watchdog protects a local master against a transfer that never finishes. The watchdog runs only while the master is ready and the bus is busy. Any clock-line edge reloads it. When it expires, it raises a sticky timeout flag and a soft-reset request. A pulse on the soft-reset input clears all monitor state and withdraws master readiness. Master readiness returns only on a fresh low-to-high transition of the master enable input.

Top module: `i2c_busmon`

## Requirements
- R1: A START strobe (`start_pulse`, one cycle) is produced only when the filtered data line goes 1→0 while the filtered clock line is 1 in both the old and new sample. If both lines fall in the same sample, no START is produced.
- R2: A STOP is the filtered data line going 0→1 while the clock line is 1 in both samples. It produces a one-cycle `stop_pulse` and leaves `bus_busy` at 0.
- R3: A START seen while `bus_busy` is 1 produces `rstart_pulse` instead of `start_pulse`, and `bus_busy` stays 1.
- R4: `bus_busy` is 0 after reset, becomes 1 on a START, and follows the START/STOP history for any line sequence.
- R5: Both lines held low together for 625 cycles (2.5 µs at the bench clock) and then released leaves `bus_busy` at 0, `void_flag` at 0, and no START counted. This holds whether the two lines are released together or the clock line is released first.
- R6: A STOP while busy with zero clock-line falls since the last START gives a one-cycle `void_pulse` in the same cycle as `stop_pulse`. It also sets `void_flag`, which stays 1 until a soft reset, and leaves the bus free.
- R7: While `master_ready` and `bus_busy` are both 1, the watchdog counts clock cycles. Any filtered clock-line edge restarts the count. If about `tmo_limit`+1 cycles pass with no edge, `timeout_flag` sets. Edges spaced closer than `tmo_limit` never set it.
- R8: The watchdog does not advance while the bus is free or `master_ready` is 0.
- R9: An expiry sets both `timeout_flag` and `rst_req`. Both stay 1 until `soft_rst` is seen.
- R10: One cycle of `soft_rst` clears `bus_busy`, `void_flag`, `timeout_flag`, `rst_req` and `master_ready`. `master_ready` becomes 1 again only after `master_en` is seen going 0→1.
- R11: A single-cycle low glitch on the data line while the clock line is high is removed by the majority filter. It produces no START and does not change `bus_busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_in | input | 1 | Raw clock-line sample |
| sda_in | input | 1 | Raw data-line sample |
| tmo_limit | input | TMO_W | Watchdog limit in system clock cycles |
| soft_rst | input | 1 | Synchronous soft reset / acknowledge of the reset request |
| master_en | input | 1 | Master enable; a 0→1 transition arms master readiness |
| start_pulse | output | 1 | One-cycle START strobe (bus was free) |
| rstart_pulse | output | 1 | One-cycle repeated START strobe |
| stop_pulse | output | 1 | One-cycle STOP strobe |
| void_pulse | output | 1 | One-cycle empty-message strobe |
| bus_busy | output | 1 | Bus busy status |
| void_flag | output | 1 | Sticky empty-message flag |
| timeout_flag | output | 1 | Sticky watchdog expiry flag |
| rst_req | output | 1 | Soft-reset request, held until `soft_rst` |
| master_ready | output | 1 | Master armed and ready for a transfer |

## Verification
The bench builds the monitor with an 8-bit `TMO_W` and drives `tmo_limit` to 20 cycles. This brings both the expiry path and the reload-by-edge path within a few dozen cycles. It also allows the full 625-cycle boot-time low pattern. The filter keeps its default two synchronizer stages and three majority taps. Every line level is therefore held for ten or more cycles, which covers the six-cycle path from pin to strobe. The same filter settings let a one-cycle glitch be shown to vanish.

// File: rtl/i2c_busmon_pkg.sv
package i2c_busmon_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_SCL  = 1;
  localparam int unsigned LINE_SDA  = 0;

  typedef logic [NUM_LINES-1:0] i2c_lines_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned TAPS   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_out
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic [TAPS-1:0]   hist_q, hist_d;
  logic              filt_q, filt_d;
  int                ones;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], line_in};
    hist_d = {hist_q[TAPS-2:0], sync_q[STAGES-1]};
    ones   = 0;
    for (int i = 0; i < int'(TAPS); i++) begin
      ones = ones + int'(hist_q[i]);
    end
    filt_d = (ones > int'(TAPS / 2));
  end

  // lines idle high: reset to 1 so release creates no false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      filt_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign line_out = filt_q;

  // a level seen in every tap must be the filter output next cycle
  AST_FILTER_UNANIMOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (&hist_q) |=> filt_q); // R11
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int unsigned FALL_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic scl,
  input  logic sda,
  output logic start_p,
  output logic rstart_p,
  output logic stop_p,
  output logic void_p,
  output logic busy,
  output logic void_flag,
  output logic scl_edge
);
  localparam logic [FALL_W-1:0] FALL_MAX = '1;

  logic              scl_q, sda_q;
  logic              busy_q, busy_d;
  logic [FALL_W-1:0] falls_q, falls_d;
  logic              start_q, start_d, rstart_q, rstart_d;
  logic              stop_q, stop_d, void_q, void_d;
  logic              vflag_q, vflag_d;
  logic              scl_high, start_c, stop_c, scl_fall_c, void_c;

  always_comb begin
    scl_high   = scl_q & scl;
    start_c    = scl_high & sda_q & ~sda;
    stop_c     = scl_high & ~sda_q & sda;
    scl_fall_c = scl_q & ~scl;
    void_c     = stop_c & busy_q & (falls_q == '0);

    busy_d = busy_q;
    if (clr)          busy_d = 1'b0;
    else if (start_c) busy_d = 1'b1;
    else if (stop_c)  busy_d = 1'b0;

    falls_d = falls_q;
    if (clr || start_c)
      falls_d = '0;
    else if (scl_fall_c && busy_q && falls_q != FALL_MAX)
      falls_d = falls_q + 1'b1;

    start_d  = start_c & ~busy_q & ~clr;
    rstart_d = start_c & busy_q & ~clr;
    stop_d   = stop_c & ~clr;
    void_d   = void_c & ~clr;
    vflag_d  = clr ? 1'b0 : (vflag_q | void_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      busy_q   <= 1'b0;
      falls_q  <= '0;
      start_q  <= 1'b0;
      rstart_q <= 1'b0;
      stop_q   <= 1'b0;
      void_q   <= 1'b0;
      vflag_q  <= 1'b0;
    end else begin
      scl_q    <= scl;
      sda_q    <= sda;
      busy_q   <= busy_d;
      falls_q  <= falls_d;
      start_q  <= start_d;
      rstart_q <= rstart_d;
      stop_q   <= stop_d;
      void_q   <= void_d;
      vflag_q  <= vflag_d;
    end
  end

  assign start_p   = start_q;
  assign rstart_p  = rstart_q;
  assign stop_p    = stop_q;
  assign void_p    = void_q;
  assign busy      = busy_q;
  assign void_flag = vflag_q;
  assign scl_edge  = scl_q ^ scl;

  AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_q, rstart_q, stop_q})); // R1
  AST_STOP_FREES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !busy_q); // R2
  AST_RSTART_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_q |-> (busy_q && $past(busy_q))); // R3
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> (busy_q && !$past(busy_q))); // R4
  AST_VOID_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    void_q |-> (stop_q && vflag_q && !busy_q)); // R6
  AST_VOID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (vflag_q && !clr) |=> vflag_q); // R6
endmodule

// File: rtl/i2c_xfer_watchdog.sv
module i2c_xfer_watchdog #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             master_en,
  input  logic             busy,
  input  logic             scl_edge,
  input  logic [TMO_W-1:0] limit,
  output logic             timeout_flag,
  output logic             rst_req,
  output logic             master_ready
);
  logic             en_q;
  logic             ready_q, ready_d;
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic             tmo_q, tmo_d;
  logic             req_q, req_d;
  logic             pending, expire;

  always_comb begin
    pending = ready_q & busy & ~tmo_q;
    expire  = pending & ~scl_edge & (cnt_q >= limit);

    ready_d = ready_q;
    if (clr || !master_en)  ready_d = 1'b0;
    else if (!en_q)         ready_d = 1'b1;

    if (clr || !pending || scl_edge) cnt_d = '0;
    else if (cnt_q >= limit)          cnt_d = cnt_q;
    else                              cnt_d = cnt_q + 1'b1;

    tmo_d = clr ? 1'b0 : (tmo_q | expire);
    req_d = clr ? 1'b0 : (req_q | expire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ready_q <= 1'b0;
      cnt_q   <= '0;
      tmo_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      en_q    <= master_en;
      ready_q <= ready_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
      req_q   <= req_d;
    end
  end

  assign timeout_flag = tmo_q;
  assign rst_req      = req_q;
  assign master_ready = ready_q;

  AST_TMO_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(ready_q && busy)); // R7
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $past(ready_q && busy)); // R8
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !clr) |=> req_q); // R9
  AST_SOFT_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!ready_q && !req_q && !tmo_q)); // R10
endmodule

// File: rtl/i2c_busmon.sv
module i2c_busmon
  import i2c_busmon_pkg::*;
#(
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned FALL_W      = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAJ_TAPS    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             soft_rst,
  input  logic             master_en,
  output logic             start_pulse,
  output logic             rstart_pulse,
  output logic             stop_pulse,
  output logic             void_pulse,
  output logic             bus_busy,
  output logic             void_flag,
  output logic             timeout_flag,
  output logic             rst_req,
  output logic             master_ready
);
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  i2c_lines_t raw_lines, filt_lines;
  logic       busy, scl_edge;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  always_comb begin
    raw_lines           = '0;
    raw_lines[LINE_SCL] = scl_in;
    raw_lines[LINE_SDA] = sda_in;
  end

  for (genvar g = 0; g < int'(NUM_LINES); g++) begin : g_line
    i2c_line_filter #(
      .STAGES(SYNC_STAGES),
      .TAPS  (MAJ_TAPS)
    ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .line_in (raw_lines[g]),
      .line_out(filt_lines[g])
    );
  end

  i2c_cond_detect #(.FALL_W(FALL_W)) u_cond (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (soft_rst),
    .scl      (filt_lines[LINE_SCL]),
    .sda      (filt_lines[LINE_SDA]),
    .start_p  (start_pulse),
    .rstart_p (rstart_pulse),
    .stop_p   (stop_pulse),
    .void_p   (void_pulse),
    .busy     (busy),
    .void_flag(void_flag),
    .scl_edge (scl_edge)
  );

  i2c_xfer_watchdog #(.TMO_W(TMO_W)) u_wdog (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .clr         (soft_rst),
    .master_en   (master_en),
    .busy        (busy),
    .scl_edge    (scl_edge),
    .limit       (tmo_limit),
    .timeout_flag(timeout_flag),
    .rst_req     (rst_req),
    .master_ready(master_ready)
  );

  assign bus_busy = busy;
endmodule

// File: tb/i2c_busmon_bench.sv
module i2c_busmon_bench;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl_in, sda_in, soft_rst, master_en;
  logic [TW-1:0] tmo_limit;
  logic start_pulse, rstart_pulse, stop_pulse, void_pulse;
  logic bus_busy, void_flag, timeout_flag, rst_req, master_ready;

  int checks = 0;
  int failures = 0;
  int n_start = 0, n_rstart = 0, n_stop = 0, n_void = 0;
  int b_start, b_rstart, b_stop, b_void;
  int cycles = 0;

  always #2 clk = ~clk;

  i2c_busmon #(.TMO_W(TW)) u_i2c_busmon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .tmo_limit(tmo_limit), .soft_rst(soft_rst), .master_en(master_en),
    .start_pulse(start_pulse), .rstart_pulse(rstart_pulse),
    .stop_pulse(stop_pulse), .void_pulse(void_pulse), .bus_busy(bus_busy),
    .void_flag(void_flag), .timeout_flag(timeout_flag), .rst_req(rst_req),
    .master_ready(master_ready)
  );

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (start_pulse)  n_start  <= n_start + 1;
    if (rstart_pulse) n_rstart <= n_rstart + 1;
    if (stop_pulse)   n_stop   <= n_stop + 1;
    if (void_pulse)   n_void   <= n_void + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic s, input logic d, input int n);
    @(negedge clk);
    scl_in = s;
    sda_in = d;
    repeat (n) @(negedge clk);
  endtask

  task automatic snap();
    @(negedge clk);
    b_start = n_start; b_rstart = n_rstart; b_stop = n_stop; b_void = n_void;
  endtask

  // {scl, sda, expected bus_busy}
  localparam logic [2:0] VEC [10] = '{
    3'b110, 3'b101, 3'b001, 3'b011, 3'b111,
    3'b011, 3'b001, 3'b101, 3'b110, 3'b110
  };

  initial begin
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; soft_rst = 1'b0;
    master_en = 1'b0; tmo_limit = 8'd20;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R4, R10)
    chk("R4 busy after reset", int'(bus_busy), 0);
    chk("R10 ready after reset", int'(master_ready), 0);
    chk("R9 flags after reset", int'({timeout_flag, rst_req, void_flag}), 0);

    // table walk: one normal transfer with two clock pulses
    snap();
    for (int i = 0; i < 10; i++) begin
      hold(VEC[i][2], VEC[i][1], 10);
      chk($sformatf("R4 vector %0d busy", i), int'(bus_busy), int'(VEC[i][0]));
    end
    chk("R1 one start in table", n_start - b_start, 1);
    chk("R2 one stop in table", n_stop - b_stop, 1);
    chk("R6 no void in table", n_void - b_void, 0);

    // R11: single-cycle SDA glitch
    snap();
    @(negedge clk) sda_in = 1'b0;
    @(negedge clk) sda_in = 1'b1;
    hold(1, 1, 10);
    chk("R11 glitch no start", n_start - b_start, 0);
    chk("R11 glitch busy", int'(bus_busy), 0);

    // R5 / R1: boot pattern, both lines low together then released
    snap();
    hold(0, 0, 625);
    hold(1, 1, 20);
    chk("R1 simultaneous fall no start", n_start - b_start, 0);
    chk("R5 busy after boot low", int'(bus_busy), 0);
    hold(0, 0, 625);
    hold(1, 0, 10);
    hold(1, 1, 10);
    chk("R5 staggered release busy", int'(bus_busy), 0);
    chk("R5 no void flag", int'(void_flag), 0);
    chk("R5 no start", n_start - b_start, 0);

    // R3: repeated start
    snap();
    hold(1, 0, 10); hold(0, 0, 10); hold(0, 1, 10); hold(1, 1, 10);
    hold(1, 0, 10);
    chk("R3 rstart count", n_rstart - b_rstart, 1);
    chk("R3 start count", n_start - b_start, 1);
    chk("R3 busy kept", int'(bus_busy), 1);
    hold(0, 0, 10); hold(1, 0, 10); hold(1, 1, 10);
    chk("R2 stop frees", int'(bus_busy), 0);
    chk("R2 stop count", n_stop - b_stop, 1);

    // R6: void message
    snap();
    hold(1, 0, 10);
    hold(1, 1, 10);
    chk("R6 void pulse", n_void - b_void, 1);
    chk("R6 void flag", int'(void_flag), 1);
    chk("R6 bus free", int'(bus_busy), 0);
    hold(1, 1, 30);
    chk("R6 void sticky", int'(void_flag), 1);

    // R10 arm, R8 idle no timeout
    @(negedge clk) master_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 ready on enable", int'(master_ready), 1);
    hold(1, 1, 80);
    chk("R8 idle no timeout", int'(timeout_flag), 0);

    // R7: edges every 12 cycles keep watchdog quiet
    hold(1, 0, 10);
    for (int k = 0; k < 8; k++) begin
      hold(0, 0, 12);
      hold(1, 0, 12);
    end
    chk("R7 reload no timeout", int'(timeout_flag), 0);
    hold(1, 1, 10);
    chk("R7 transfer ended", int'(bus_busy), 0);

    // R7/R9: stalled transfer expires
    hold(1, 0, 60);
    chk("R7 stall timeout", int'(timeout_flag), 1);
    chk("R9 reset request", int'(rst_req), 1);
    hold(1, 0, 30);
    chk("R9 request held", int'(rst_req), 1);

    // R10: soft reset
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk) soft_rst = 1'b0;
    chk("R10 busy cleared", int'(bus_busy), 0);
    chk("R10 flags cleared", int'({timeout_flag, rst_req, void_flag}), 0);
    chk("R10 ready cleared", int'(master_ready), 0);
    hold(1, 1, 10);
    hold(1, 0, 60);
    chk("R8 not ready no timeout", int'(timeout_flag), 0);
    chk("R10 ready stays low", int'(master_ready), 0);
    hold(1, 1, 10);
    @(negedge clk) master_en = 1'b0;
    @(negedge clk) master_en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 ready after re-enable", int'(master_ready), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule